// File: doc/BRIEF.md
# Packed-Nibble Granule Tag Checker

The block decides whether a memory access carries the right colour. Memory is split into 16-byte granules. Each granule owns a 4-bit tag. Tags sit two to a byte in a separate tag store, so one tag byte covers 32 bytes of data. The pointer carries its own 4-bit tag in bits 59:56. A check compares that tag against the stored tag of every granule the access touches.

A request is a one-cycle `start` pulse. It carries the access address, the access length minus one, two tag-checking enables, and a wildcard tag that always matches. If checking is off for the half of the address space that bit 55 selects, the block reports the access as unchecked. If the wildcard matches the pointer tag, the block reports a pass. In both cases it reads no tag memory.

Otherwise the block reads tag bytes one after another through a byte-wide port with one cycle of latency. It compares every nibble the access covers and stops at the first mismatch. A failure comes back with the address of the first failing granule, so a fault can be reported precisely.

Top module: `tag_range_checker`

## Requirements
- R1: The first tag read uses byte index `addr >> 5`. Each following read uses the previous index plus one. `rd_data` is the byte at the index that `rd_en` presented on the previous clock edge.
- R2: In each tag byte, bits 3:0 hold the tag of the granule whose address bit 4 is 0, and bits 7:4 hold the tag of the granule whose address bit 4 is 1. When address bit 4 is set, checking begins at bits 7:4 of the first byte.
- R3: The number of granules checked is `(((addr+size_m1) & ~15) - (addr & ~15)) / 16 + 1`. For a pass, the bytes read are exactly those from index `addr>>5` to `(addr+size_m1)>>5`.
- R4: The expected tag is `addr[59:56]`. A granule matches only when its stored nibble equals that tag.
- R5: Bit 55 of the address selects `chk_hi_en` (when 1) or `chk_lo_en` (when 0). If the selected enable is 0, `done` rises on the cycle after `start`, `result` = 2 (unchecked), and no read is issued.
- R6: If `wild_en` is 1 and `addr[59:56]` equals `wild_tag`, and R5 does not apply, `done` rises on the cycle after `start`, `result` = 0 (pass), and no read is issued. When `wild_en` is 0, the access is checked normally.
- R7: When the check fails, `result` = 1. `fault_addr` equals `addr` if the first granule fails. If granule n > 0 fails, `fault_addr` equals `(addr & ~15) + 16*n`. On a pass or an unchecked result, `fault_addr` is 0.
- R8: No read is issued after the byte that holds the first mismatching nibble. `done` rises on the cycle after that byte is compared (two cycles after its `rd_en`), and it pulses for one cycle per request.
- R9: Under reset and right after it, `done`, `busy` and `rd_en` are 0.
- R10: A `start` that arrives while `busy` is 1 is ignored. It produces no extra `done`, and the request in flight still reports its own outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only while idle |
| addr | input | ADDR_W | Access address, tag in bits 59:56 |
| size_m1 | input | SIZE_W | Access length in bytes minus one |
| chk_lo_en | input | 1 | Tag checking enabled when addr bit 55 is 0 |
| chk_hi_en | input | 1 | Tag checking enabled when addr bit 55 is 1 |
| wild_en | input | 1 | Enables the wildcard tag |
| wild_tag | input | 4 | Pointer tag that always passes |
| rd_en | output | 1 | Tag memory read strobe |
| rd_idx | output | ADDR_W-5 | Tag byte index |
| rd_data | input | 8 | Tag byte, valid one cycle after rd_en |
| busy | output | 1 | A checked request is in progress |
| done | output | 1 | One-cycle outcome strobe |
| result | output | 2 | 0 pass, 1 fail, 2 unchecked |
| fault_addr | output | ADDR_W | First failing granule address |

## Verification
A corrupted granule counter shows up at the ports. It either reports `fault_addr` one granule off, or it stops the pass early, and the bench sees too few reads on the `done` strobe of that same request. A stuck nibble-select flag starts the check on the wrong half of the byte. That gives a wrong verdict within one read. A sequencer that does not stop on a mismatch issues one more `rd_en` before `done`, and the monitor flags it at the strobe. Each request is scored at its own `done`, so any fault is reported no later than the end of the request that exposed it.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;

    localparam int TAG_W   = 4;
    localparam int GRAN_LG = 4;
    localparam int BYTE_LG = GRAN_LG + 1;

    typedef enum logic [1:0] {
        RES_PASS  = 2'd0,
        RES_FAIL  = 2'd1,
        RES_UNCHK = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        K_CHECK      = 2'd0,
        K_SKIP_UNCHK = 2'd1,
        K_SKIP_PASS  = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_CHECK = 2'd2
    } state_e;

    function automatic logic [2*TAG_W-1:0] rep_tag(input logic [TAG_W-1:0] t);
        return {t, t};
    endfunction

endpackage

// File: rtl/tagchk_setup.sv
module tagchk_setup
    import tagchk_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int SIZE_W  = 8,
    parameter int TAG_LSB = 56,
    parameter int SEL_BIT = 55,
    parameter int IDX_W   = ADDR_W - BYTE_LG,
    parameter int CNT_W   = SIZE_W - GRAN_LG + 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size_m1,
    input  logic              chk_lo_en,
    input  logic              chk_hi_en,
    input  logic              wild_en,
    input  logic [TAG_W-1:0]  wild_tag,
    output kind_e             kind,
    output logic [TAG_W-1:0]  exp_tag,
    output logic [IDX_W-1:0]  first_idx,
    output logic              start_odd,
    output logic [CNT_W-1:0]  gran_cnt
);
    localparam int GW = ADDR_W - GRAN_LG;

    logic [ADDR_W-1:0] last_b;
    logic [GW-1:0]     g_first;
    logic [GW-1:0]     g_last;
    logic [GW-1:0]     g_span;
    logic              chk_on;

    always_comb begin
        last_b    = addr + ADDR_W'(size_m1);
        g_first   = addr[ADDR_W-1:GRAN_LG];
        g_last    = last_b[ADDR_W-1:GRAN_LG];
        g_span    = g_last - g_first;
        gran_cnt  = CNT_W'(g_span) + CNT_W'(1);
        exp_tag   = addr[TAG_LSB +: TAG_W];
        first_idx = addr[ADDR_W-1:BYTE_LG];
        start_odd = addr[GRAN_LG];
        chk_on    = addr[SEL_BIT] ? chk_hi_en : chk_lo_en;
        if (!chk_on)
            kind = K_SKIP_UNCHK;
        else if (wild_en && (exp_tag == wild_tag))
            kind = K_SKIP_PASS;
        else
            kind = K_CHECK;
    end
endmodule

// File: rtl/tagchk_nibble_cmp.sv
module tagchk_nibble_cmp
    import tagchk_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [2*TAG_W-1:0] tag_byte,
    input  logic [TAG_W-1:0]   exp_tag,
    input  logic               odd,
    input  logic [CNT_W-1:0]   n_in,
    input  logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   n_out,
    output logic               mismatch,
    output logic               finished
);
    logic [2*TAG_W-1:0] diff;
    logic [1:0]         lane_bad;
    logic [CNT_W-1:0]   n1;

    assign diff = tag_byte ^ rep_tag(exp_tag);

    for (genvar i = 0; i < 2; i++) begin : g_lane
        assign lane_bad[i] = |diff[i*TAG_W +: TAG_W];
    end

    always_comb begin
        n1       = n_in;
        n_out    = n_in;
        mismatch = 1'b0;
        finished = 1'b0;
        if (!odd) begin
            if (lane_bad[0]) mismatch = 1'b1;
            else             n1 = n_in + CNT_W'(1);
        end
        if (!mismatch) begin
            if (n1 == cnt) begin
                finished = 1'b1;
                n_out    = n1;
            end else if (lane_bad[1]) begin
                mismatch = 1'b1;
                n_out    = n1;
            end else begin
                n_out    = n1 + CNT_W'(1);
                finished = (n_out == cnt);
            end
        end
    end
endmodule

// File: rtl/tagchk_seq.sv
module tagchk_seq
    import tagchk_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = ADDR_W - BYTE_LG,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  kind_e             kind,
    input  logic [TAG_W-1:0]  exp_tag,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic              start_odd,
    input  logic [CNT_W-1:0]  gran_cnt,
    input  logic [CNT_W-1:0]  n_out,
    input  logic              mismatch,
    input  logic              finished,
    output logic [TAG_W-1:0]  exp_q,
    output logic              odd_q,
    output logic [CNT_W-1:0]  n_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              busy,
    output logic              done,
    output res_e              result,
    output logic [ADDR_W-1:0] fault_addr
);
    state_e            state;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              done_q;
    res_e              res_q;
    logic [ADDR_W-1:0] fault_q;
    logic [ADDR_W-1:0] base_q;

    assign base_q     = {addr_q[ADDR_W-1:GRAN_LG], GRAN_LG'(0)};
    assign rd_en      = (state == S_ISSUE);
    assign rd_idx     = idx_q;
    assign busy       = (state != S_IDLE);
    assign done       = done_q;
    assign result     = res_q;
    assign fault_addr = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            addr_q  <= '0;
            idx_q   <= '0;
            exp_q   <= '0;
            odd_q   <= 1'b0;
            n_q     <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            res_q   <= RES_PASS;
            fault_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        case (kind)
                            K_SKIP_UNCHK: begin
                                done_q  <= 1'b1;
                                res_q   <= RES_UNCHK;
                                fault_q <= '0;
                            end
                            K_SKIP_PASS: begin
                                done_q  <= 1'b1;
                                res_q   <= RES_PASS;
                                fault_q <= '0;
                            end
                            default: begin
                                addr_q <= addr;
                                idx_q  <= first_idx;
                                exp_q  <= exp_tag;
                                odd_q  <= start_odd;
                                cnt_q  <= gran_cnt;
                                n_q    <= '0;
                                state  <= S_ISSUE;
                            end
                        endcase
                    end
                end
                S_ISSUE: state <= S_CHECK;
                S_CHECK: begin
                    if (mismatch) begin
                        done_q  <= 1'b1;
                        res_q   <= RES_FAIL;
                        fault_q <= (n_out == '0) ? addr_q
                                 : base_q + (ADDR_W'(n_out) << GRAN_LG);
                        state   <= S_IDLE;
                    end else if (finished) begin
                        done_q  <= 1'b1;
                        res_q   <= RES_PASS;
                        fault_q <= '0;
                        state   <= S_IDLE;
                    end else begin
                        n_q   <= n_out;
                        idx_q <= idx_q + IDX_W'(1);
                        odd_q <= 1'b0;
                        state <= S_ISSUE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R5
    skip_unchk_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start && kind == K_SKIP_UNCHK)
        |=> (done && result == RES_UNCHK && !rd_en));

    // R6
    skip_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start && kind == K_SKIP_PASS)
        |=> (done && result == RES_PASS && !rd_en));

    // R8
    stop_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_CHECK && mismatch) |=> (done && result == RES_FAIL && !rd_en));

    // R8
    no_done_after_issue_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !done);

    // R7
    fault_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_CHECK && mismatch && n_out != '0) |=> (fault_addr[GRAN_LG-1:0] == '0));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(addr_q));
endmodule

// File: rtl/tag_range_checker.sv
module tag_range_checker
    import tagchk_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int SIZE_W  = 8,
    parameter int TAG_LSB = 56,
    parameter int SEL_BIT = 55,
    localparam int IDX_W  = ADDR_W - BYTE_LG,
    localparam int CNT_W  = SIZE_W - GRAN_LG + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size_m1,
    input  logic              chk_lo_en,
    input  logic              chk_hi_en,
    input  logic              wild_en,
    input  logic [3:0]        wild_tag,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [ADDR_W-1:0] fault_addr
);
    kind_e            kind;
    logic [TAG_W-1:0] exp_tag;
    logic [IDX_W-1:0] first_idx;
    logic             start_odd;
    logic [CNT_W-1:0] gran_cnt;
    logic [TAG_W-1:0] exp_q;
    logic             odd_q;
    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] n_out;
    logic             mismatch;
    logic             finished;
    res_e             res_w;

    assign result = res_w;

    tagchk_setup #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TAG_LSB(TAG_LSB),
        .SEL_BIT(SEL_BIT), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_setup (
        .addr(addr), .size_m1(size_m1), .chk_lo_en(chk_lo_en),
        .chk_hi_en(chk_hi_en), .wild_en(wild_en), .wild_tag(wild_tag),
        .kind(kind), .exp_tag(exp_tag), .first_idx(first_idx),
        .start_odd(start_odd), .gran_cnt(gran_cnt)
    );

    tagchk_nibble_cmp #(.CNT_W(CNT_W)) u_cmp (
        .tag_byte(rd_data), .exp_tag(exp_q), .odd(odd_q), .n_in(n_q),
        .cnt(cnt_q), .n_out(n_out), .mismatch(mismatch), .finished(finished)
    );

    tagchk_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .addr(addr), .kind(kind),
        .exp_tag(exp_tag), .first_idx(first_idx), .start_odd(start_odd),
        .gran_cnt(gran_cnt), .n_out(n_out), .mismatch(mismatch),
        .finished(finished), .exp_q(exp_q), .odd_q(odd_q), .n_q(n_q),
        .cnt_q(cnt_q), .rd_en(rd_en), .rd_idx(rd_idx), .busy(busy),
        .done(done), .result(res_w), .fault_addr(fault_addr)
    );

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> busy);
endmodule

// File: tb/tag_range_checker_bench.sv
module tag_range_checker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] addr = '0;
    logic [7:0]  size_m1 = '0;
    logic        chk_lo_en = 1'b0;
    logic        chk_hi_en = 1'b0;
    logic        wild_en = 1'b0;
    logic [3:0]  wild_tag = '0;
    logic        rd_en;
    logic [58:0] rd_idx;
    logic [7:0]  rd_data = '0;
    logic        busy;
    logic        done;
    logic [1:0]  result;
    logic [63:0] fault_addr;

    logic [7:0] tmem [64];

    typedef struct {
        logic [1:0]  res;
        logic [63:0] fault;
        int          reads;
        logic [5:0]  idx0;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   errs = 0;
    int   nchk = 0;
    int   rd_cnt = 0;

    always #5 clk = ~clk;

    tag_range_checker u_tag_range_checker (
        .clk(clk), .rst(rst), .start(start), .addr(addr), .size_m1(size_m1),
        .chk_lo_en(chk_lo_en), .chk_hi_en(chk_hi_en), .wild_en(wild_en),
        .wild_tag(wild_tag), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .done(done), .result(result), .fault_addr(fault_addr)
    );

    always @(posedge clk) if (rd_en) rd_data <= tmem[rd_idx[5:0]];

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [3:0] tag, input logic b55,
                                       input logic [10:0] low);
        return {4'h0, tag, b55, 44'h0, low};
    endfunction

    function automatic exp_t model(input logic [63:0] a, input logic [7:0] sz,
                                   input logic tlo, input logic thi,
                                   input logic men, input logic [3:0] mt,
                                   input string req);
        exp_t e;
        logic [3:0]  tag;
        logic [63:0] first, last, ga;
        logic [7:0]  b;
        logic [3:0]  nib;
        int          cnt;
        tag    = a[59:56];
        e.req  = req;
        e.idx0 = a[10:5];
        e.fault = '0;
        if (!(a[55] ? thi : tlo)) begin
            e.res = 2'd2; e.reads = 0; return e;
        end
        if (men && tag == mt) begin
            e.res = 2'd0; e.reads = 0; return e;
        end
        first = a & ~64'hF;
        last  = (a + 64'(sz)) & ~64'hF;
        cnt   = int'((last - first) >> 4) + 1;
        e.res   = 2'd0;
        e.reads = int'((last >> 5) - (a >> 5)) + 1;
        for (int g = 0; g < cnt; g++) begin
            ga  = first + 64'(g) * 64'd16;
            b   = tmem[ga[10:5]];
            nib = ga[4] ? b[7:4] : b[3:0];
            if (nib != tag) begin
                e.res   = 2'd1;
                e.fault = (g == 0) ? a : ga;
                e.reads = int'((ga >> 5) - (a >> 5)) + 1;
                break;
            end
        end
        return e;
    endfunction

    task automatic run_case(input logic [63:0] a, input logic [7:0] sz,
                            input logic tlo, input logic thi,
                            input logic men, input logic [3:0] mt,
                            input bit poke, input string req);
        sb.push_back(model(a, sz, tlo, thi, men, mt, req));
        @(negedge clk);
        addr = a; size_m1 = sz; chk_lo_en = tlo; chk_hi_en = thi;
        wild_en = men; wild_tag = mt; start = 1'b1;
        @(negedge clk);
        if (poke) begin
            addr = mk(4'h0, 1'b0, 11'h0); chk_lo_en = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_en) begin
                if (sb.size() == 0) begin
                    check("R8", "read with nothing pending", 64'd1, 64'd0);
                end else begin
                    check("R1", "read index", 64'(rd_idx[5:0]),
                          64'(sb[0].idx0 + 6'(rd_cnt)));
                end
                rd_cnt++;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    check("R10", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.req, "result", 64'(result), 64'(e.res));
                    check("R7", {e.req, " fault_addr"}, fault_addr, e.fault);
                    check("R8", {e.req, " reads"}, 64'(rd_cnt), 64'(e.reads));
                end
                rd_cnt = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) tmem[i] = 8'h55;
        tmem[2] = 8'h57;
        tmem[3] = 8'h75;
        tmem[6] = 8'h59;
        repeat (3) @(negedge clk);
        // R9 during reset
        check("R9", "done in reset", 64'(done), 64'd0);
        check("R9", "rd_en in reset", 64'(rd_en), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "busy after reset", 64'(busy), 64'd0);
        check("R9", "done after reset", 64'(done), 64'd0);
        // R1 R4: one granule, low nibble
        run_case(mk(4'h5, 1'b1, 11'h000), 8'd15, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, "R4");
        // R2: odd start, high nibble only
        run_case(mk(4'h5, 1'b1, 11'h010), 8'd15, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, "R2");
        // R3: odd start crossing into next byte
        run_case(mk(4'h5, 1'b1, 11'h018), 8'd15, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, "R3");
        // R4: wrong pointer tag fails on first granule
        run_case(mk(4'h6, 1'b1, 11'h008), 8'd3, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, "R4");
        // R7: first granule fails, fault is the raw address
        run_case(mk(4'h5, 1'b0, 11'h044), 8'd31, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, "R7");
        // R7 R8: second granule in same byte fails, later bytes not read
        run_case(mk(4'h5, 1'b0, 11'h064), 8'd63, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, "R7");
        // R8: failure in a later byte
        run_case(mk(4'h5, 1'b0, 11'h0A8), 8'd64, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, "R8");
        // R5: checking disabled in low half
        run_case(mk(4'h5, 1'b0, 11'h040), 8'd31, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, "R5");
        // R5: checking disabled in high half
        run_case(mk(4'h5, 1'b1, 11'h040), 8'd31, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, "R5");
        // R5: high half enabled, low disabled, still checked
        run_case(mk(4'h5, 1'b1, 11'h040), 8'd31, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, "R5");
        // R6: wildcard tag passes over bad bytes
        run_case(mk(4'hF, 1'b0, 11'h040), 8'd95, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, "R6");
        // R6: wildcard disabled, same access checked
        run_case(mk(4'hF, 1'b0, 11'h040), 8'd95, 1'b1, 1'b1, 1'b0, 4'hF, 1'b0, "R6");
        // R6: wildcard value differs from pointer tag
        run_case(mk(4'h5, 1'b0, 11'h040), 8'd31, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, "R6");
        // R3: long pass, 17 granules across 9 bytes
        run_case(mk(4'h5, 1'b0, 11'h208), 8'd255, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, "R3");
        // R10: start while busy is ignored
        run_case(mk(4'h5, 1'b0, 11'h0A8), 8'd64, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1, "R10");
        repeat (4) @(negedge clk);
        check("R10", "pending after poke", 64'(sb.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule